// File: doc/BRIEF.md
# Link Active-State Power Controller

This block manages the power state of one end of a serial point-to-point link. It tracks six link conditions: fully active, transmit standby, low-power standby, staged for power removal, powered down, and a short recovery phase on the way back to full activity. A two-bit enable field turns the two hardware-driven savings, transmit standby and low-power standby, on or off independently. The same field decides whether an L1 entry request from the far end gets a positive or a negative answer.

The device power state sits above the enable field. Any non-D0 device state forces the link into low-power standby, whatever the enable field holds. A turn-off notice in D3hot moves the link to the staging condition. A cold device state drops the link to powered down. When the device returns to D0 from a low-power condition, the link passes through recovery before packets may flow again. The physical layer, packet building and electrical idle detection are outside the block. They reach it only as single-bit handshakes.

Top module: `link_pm_ctrl`

## Requirements
- R1: After reset `link_state` is 0 (active), `tx_allowed` is 1 and `ack_pos`, `ack_neg`, `tx_l1_req` and `turnoff_ack` are 0. The link-state codes are: 0 active, 1 transmit standby, 2 low-power standby, 3 staged for power removal, 4 powered down, 5 recovery.
- R2: With device state D0 (code 0) and `aspm_ctl[0]`=1, the link moves from code 0 to code 1 on the clock edge that completes 16 consecutive cycles with `tx_pending` low. With `aspm_ctl[0]`=0 it never enters code 1.
- R3: In code 1 with D0, the first cycle with `tx_pending` high returns the link to code 0 on the next edge. `tx_allowed` is 1 only in code 0.
- R4: An `rx_l1_req` sampled in any code except 3 and 4 produces a one-cycle answer on the next edge. The answer is `ack_pos` when `aspm_ctl[1]`=1 and `ack_neg` when `aspm_ctl[1]`=0. A positive answer given in code 0 or 1 also moves the link to code 2 on that edge. A negative answer leaves the state unchanged.
- R5: With D0 and `aspm_ctl[1]`=1, the edge that completes 64 consecutive idle cycles moves the link from code 0 or 1 to code 2. On that same edge `tx_l1_req` pulses for one cycle. With `aspm_ctl[1]`=0 no request is ever sent.
- R6: In code 2 with D0, `tx_pending` high moves the link to code 5. The link stays in code 5 for 4 cycles and then goes to code 0.
- R7: Device states D1 (1), D2 (2) and D3hot (3) move the link from codes 0, 1 or 5 to code 2 on the next edge, whatever `aspm_ctl` holds.
- R8: `turnoff_req` sampled while the link is in code 2 with D3hot moves the link to code 3, and `turnoff_ack` pulses on the same edge. In every other situation `turnoff_req` is ignored: no acknowledge and no state change.
- R9: An `rx_l1_req` sampled in code 3 or 4 gets no acknowledge of either kind, and the state does not change.
- R10: Device state codes 4 to 7 (D3cold) move the link to code 4 on the next edge from any code.
- R11: Returning the device state to D0 from codes 2, 3 or 4, after a non-D0 device state, moves the link to code 5 on the next edge. After the recovery phase it reaches code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aspm_ctl | input | 2 | Bit 0 enables transmit standby, bit 1 enables low-power standby |
| dev_state | input | 3 | Device power state: 0 D0, 1 D1, 2 D2, 3 D3hot, 4-7 D3cold |
| tx_pending | input | 1 | Transmit data is waiting |
| rx_l1_req | input | 1 | Far end requests low-power standby |
| turnoff_req | input | 1 | Turn-off notice before power removal |
| link_state | output | 3 | Current link-state code |
| tx_allowed | output | 1 | Packets may be sent |
| ack_pos | output | 1 | Positive answer to a far-end request |
| ack_neg | output | 1 | Negative answer to a far-end request |
| tx_l1_req | output | 1 | Own low-power standby request |
| turnoff_ack | output | 1 | Turn-off handshake completed |

## Verification
The hardest condition to reach is the staged power-removal state. It requires two steps in order: the device must first be placed in D3hot so that the link settles in low-power standby, and only then may a turn-off notice arrive. After that, a far-end request and a return to D0 must be applied without leaving the state early. The stimulus sweeps every non-D0 device code and applies the notice only once the forced standby has been observed. It then probes that state with a far-end request and checks the recovery path. Separately, the idle thresholds are checked exactly one cycle before and on the qualifying edge, for all four enable-field values.

// File: rtl/link_pm_pkg.sv
package link_pm_pkg;

  typedef enum logic [2:0] {
    LS_L0     = 3'd0,
    LS_L0S    = 3'd1,
    LS_L1     = 3'd2,
    LS_L23RDY = 3'd3,
    LS_L2L3   = 3'd4,
    LS_RECOV  = 3'd5
  } lstate_e;

  localparam logic [2:0] DEV_D0    = 3'd0;
  localparam logic [2:0] DEV_D3HOT = 3'd3;

  function automatic logic dev_is_cold(input logic [2:0] d);
    return d >= 3'd4;
  endfunction

endpackage

// File: rtl/lpm_idle_cnt.sv
module lpm_idle_cnt #(
  parameter int L0S_IDLE = 16,
  parameter int L1_IDLE  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic tx_pending,
  output logic l0s_hit,
  output logic l1_hit
);
  localparam int W = $clog2(L1_IDLE + 1);
  localparam logic [W-1:0] MAXV = W'(L1_IDLE);
  localparam logic [W-1:0] L0S_LAST = W'(L0S_IDLE - 1);
  localparam logic [W-1:0] L1_LAST  = W'(L1_IDLE - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_upd;

  always_comb begin
    if (!cnt_en || tx_pending) cnt_d = '0;
    else if (cnt_q != MAXV)    cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
    cnt_upd = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end

  assign l0s_hit = cnt_en && !tx_pending && (cnt_q >= L0S_LAST);
  assign l1_hit  = cnt_en && !tx_pending && (cnt_q >= L1_LAST);

endmodule

// File: rtl/lpm_recov_tmr.sv
module lpm_recov_tmr #(
  parameter int RECOV_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_recov,
  output logic done
);
  localparam int W = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC + 1);
  localparam logic [W-1:0] LAST = W'(RECOV_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_upd;

  always_comb begin
    if (!in_recov)          cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else                    cnt_d = cnt_q;
    cnt_upd = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_upd) cnt_q <= cnt_d;
  end

  assign done = in_recov && (cnt_q == LAST);

endmodule

// File: rtl/lpm_state_fsm.sv
module lpm_state_fsm
  import link_pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] aspm_ctl,
  input  logic [2:0] dev_state,
  input  logic       tx_pending,
  input  logic       rx_l1_req,
  input  logic       turnoff_req,
  input  logic       l0s_hit,
  input  logic       l1_hit,
  input  logic       recov_done,
  output lstate_e    st_q,
  output logic       ack_pos,
  output logic       ack_neg,
  output logic       tx_l1_req,
  output logic       turnoff_ack
);
  lstate_e st_d;
  logic    ackp_d, ackn_d, txreq_d, toack_d;
  logic    dev_nd0_q, dev_nd0_d;
  logic    answerable;

  assign dev_nd0_d  = (dev_state != DEV_D0);
  assign answerable = (st_q != LS_L23RDY) && (st_q != LS_L2L3);

  always_comb begin
    st_d    = st_q;
    ackp_d  = 1'b0;
    ackn_d  = 1'b0;
    txreq_d = 1'b0;
    toack_d = 1'b0;
    if (rx_l1_req && answerable) begin
      ackp_d = aspm_ctl[1];
      ackn_d = !aspm_ctl[1];
    end
    if (dev_is_cold(dev_state)) begin
      st_d = LS_L2L3;
    end else if (dev_nd0_d) begin
      case (st_q)
        LS_L0, LS_L0S, LS_RECOV: st_d = LS_L1;
        LS_L1: begin
          if (dev_state == DEV_D3HOT && turnoff_req) begin
            st_d    = LS_L23RDY;
            toack_d = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end else begin
      case (st_q)
        LS_L0, LS_L0S: begin
          if (rx_l1_req && aspm_ctl[1]) begin
            st_d = LS_L1;
          end else if (l1_hit && aspm_ctl[1]) begin
            st_d    = LS_L1;
            txreq_d = 1'b1;
          end else if (st_q == LS_L0S && tx_pending) begin
            st_d = LS_L0;
          end else if (st_q == LS_L0 && l0s_hit && aspm_ctl[0]) begin
            st_d = LS_L0S;
          end
        end
        LS_L1: if (tx_pending || dev_nd0_q) st_d = LS_RECOV;
        LS_L23RDY, LS_L2L3: st_d = LS_RECOV;
        LS_RECOV: if (recov_done) st_d = LS_L0;
        default: st_d = LS_L0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= LS_L0;
      dev_nd0_q   <= 1'b0;
      ack_pos     <= 1'b0;
      ack_neg     <= 1'b0;
      tx_l1_req   <= 1'b0;
      turnoff_ack <= 1'b0;
    end else begin
      st_q        <= st_d;
      dev_nd0_q   <= dev_nd0_d;
      ack_pos     <= ackp_d;
      ack_neg     <= ackn_d;
      tx_l1_req   <= txreq_d;
      turnoff_ack <= toack_d;
    end
  end

endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import link_pm_pkg::*;
#(
  parameter int L0S_IDLE  = 16,
  parameter int L1_IDLE   = 64,
  parameter int RECOV_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] aspm_ctl,
  input  logic [2:0] dev_state,
  input  logic       tx_pending,
  input  logic       rx_l1_req,
  input  logic       turnoff_req,
  output logic [2:0] link_state,
  output logic       tx_allowed,
  output logic       ack_pos,
  output logic       ack_neg,
  output logic       tx_l1_req,
  output logic       turnoff_ack
);
  lstate_e st;
  logic    idle_en, in_recov, l0s_hit, l1_hit, recov_done;

  assign idle_en  = (st == LS_L0) || (st == LS_L0S);
  assign in_recov = (st == LS_RECOV);

  lpm_idle_cnt #(.L0S_IDLE(L0S_IDLE), .L1_IDLE(L1_IDLE)) u_idle (
    .clk(clk), .rst_n(rst_n), .cnt_en(idle_en), .tx_pending(tx_pending),
    .l0s_hit(l0s_hit), .l1_hit(l1_hit)
  );

  lpm_recov_tmr #(.RECOV_CYC(RECOV_CYC)) u_recov (
    .clk(clk), .rst_n(rst_n), .in_recov(in_recov), .done(recov_done)
  );

  lpm_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .aspm_ctl(aspm_ctl), .dev_state(dev_state),
    .tx_pending(tx_pending), .rx_l1_req(rx_l1_req), .turnoff_req(turnoff_req),
    .l0s_hit(l0s_hit), .l1_hit(l1_hit), .recov_done(recov_done),
    .st_q(st), .ack_pos(ack_pos), .ack_neg(ack_neg),
    .tx_l1_req(tx_l1_req), .turnoff_ack(turnoff_ack)
  );

  assign link_state = st;
  assign tx_allowed = (st == LS_L0);

endmodule

// File: rtl/link_pm_ctrl_chk.sv
module link_pm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] aspm_ctl,
  input logic [2:0] dev_state,
  input logic       tx_pending,
  input logic       turnoff_req,
  input logic [2:0] link_state,
  input logic       ack_pos,
  input logic       ack_neg,
  input logic       tx_l1_req,
  input logic       turnoff_ack
);
  localparam logic [2:0] C_L0 = 3'd0, C_L0S = 3'd1, C_L1 = 3'd2,
                         C_L23 = 3'd3, C_OFF = 3'd4, C_RCV = 3'd5;

  p_l0s_needs_d0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == C_L0S) |-> ($past(dev_state) == 3'd0));

  p_l0s_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == C_L0S && tx_pending) |=> (link_state != C_L0S));

  p_ack_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_pos && ack_neg));

  p_ackpos_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pos |-> $past(aspm_ctl[1]));

  p_txreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_l1_req |-> (link_state == C_L1 && $past(aspm_ctl[1])));

  p_l23_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == C_L23 && $past(link_state) != C_L23)
      |-> ($past(dev_state) == 3'd3 && $past(turnoff_req) && turnoff_ack));

  p_no_ack_staged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pos || ack_neg) |-> ($past(link_state) != C_L23 && $past(link_state) != C_OFF));

  p_l0_via_recov_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == C_L0) |->
      ($past(link_state) == C_L0 || $past(link_state) == C_L0S || $past(link_state) == C_RCV));

endmodule

bind link_pm_ctrl link_pm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aspm_ctl(aspm_ctl), .dev_state(dev_state),
  .tx_pending(tx_pending), .turnoff_req(turnoff_req), .link_state(link_state),
  .ack_pos(ack_pos), .ack_neg(ack_neg), .tx_l1_req(tx_l1_req),
  .turnoff_ack(turnoff_ack)
);

// File: tb/link_pm_ctrl_tb.sv
module link_pm_ctrl_tb;
  localparam int L0 = 0, L0S = 1, L1 = 2, L23 = 3, OFF = 4, RCV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] aspm_ctl = 2'b00;
  logic [2:0] dev_state = 3'd0;
  logic       tx_pending = 1'b1;
  logic       rx_l1_req = 1'b0;
  logic       turnoff_req = 1'b0;
  logic [2:0] link_state;
  logic       tx_allowed, ack_pos, ack_neg, tx_l1_req, turnoff_ack;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  link_pm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .aspm_ctl(aspm_ctl), .dev_state(dev_state),
    .tx_pending(tx_pending), .rx_l1_req(rx_l1_req), .turnoff_req(turnoff_req),
    .link_state(link_state), .tx_allowed(tx_allowed), .ack_pos(ack_pos),
    .ack_neg(ack_neg), .tx_l1_req(tx_l1_req), .turnoff_ack(turnoff_ack)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tx_pending = 1'b1; rx_l1_req = 1'b0;
    turnoff_req = 1'b0; dev_state = 3'd0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic recov_to_l0(input string req);
    repeat (3) tick();
    chk(req, int'(link_state), RCV);
    tick();
    chk(req, int'(link_state), L0);
    chk(req, int'(tx_allowed), 1);
  endtask

  initial begin
    do_reset();
    chk("R1 state", int'(link_state), L0);
    chk("R1 tx_allowed", int'(tx_allowed), 1);
    chk("R1 acks", int'(ack_pos | ack_neg), 0);
    chk("R1 requests", int'(tx_l1_req | turnoff_ack), 0);

    for (int a = 0; a < 4; a++) begin
      automatic int e0 = a & 1;
      automatic int e1 = (a >> 1) & 1;
      automatic int idle_st = e0 ? L0S : L0;
      // R2 threshold and R3 exit
      do_reset();
      aspm_ctl = 2'(a);
      tx_pending = 1'b0;
      repeat (15) tick();
      chk("R2 before threshold", int'(link_state), L0);
      tick();
      chk("R2 at threshold", int'(link_state), idle_st);
      tx_pending = 1'b1;
      tick();
      chk("R3 exit", int'(link_state), L0);
      chk("R3 tx_allowed", int'(tx_allowed), 1);
      // R5 own request
      tx_pending = 1'b0;
      for (int i = 1; i <= 63; i++) begin
        tick();
        if (i == 16) chk("R2 re-entry", int'(link_state), idle_st);
      end
      chk("R5 before threshold", int'(link_state), idle_st);
      chk("R3 tx_allowed idle", int'(tx_allowed), e0 ? 0 : 1);
      tick();
      chk("R5 at threshold", int'(link_state), e1 ? L1 : idle_st);
      chk("R5 request pulse", int'(tx_l1_req), e1);
      tick();
      chk("R5 pulse ends", int'(tx_l1_req), 0);
      if (e1 != 0) begin
        tx_pending = 1'b1;
        tick();
        chk("R6 recovery", int'(link_state), RCV);
        recov_to_l0("R6 back to L0");
      end
      // R4 far request from L0
      do_reset();
      aspm_ctl = 2'(a);
      rx_l1_req = 1'b1;
      tick();
      rx_l1_req = 1'b0;
      chk("R4 ack_pos", int'(ack_pos), e1);
      chk("R4 ack_neg", int'(ack_neg), 1 - e1);
      chk("R4 state", int'(link_state), e1 ? L1 : L0);
      tick();
      chk("R4 pulse ends", int'(ack_pos | ack_neg), 0);
      // R4 far request from L0s
      if (e0 != 0) begin
        do_reset();
        aspm_ctl = 2'(a);
        tx_pending = 1'b0;
        repeat (16) tick();
        rx_l1_req = 1'b1;
        tick();
        rx_l1_req = 1'b0;
        chk("R4 from L0s", int'(link_state), e1 ? L1 : L0S);
        chk("R4 from L0s ack", int'(ack_pos), e1);
      end
    end

    // R7 forced standby from L0s despite enable field
    do_reset();
    aspm_ctl = 2'b01;
    tx_pending = 1'b0;
    repeat (16) tick();
    chk("R7 in L0s", int'(link_state), L0S);
    dev_state = 3'd1;
    tick();
    chk("R7 forced from L0s", int'(link_state), L1);

    for (int d = 1; d <= 3; d++) begin
      do_reset();
      aspm_ctl = 2'b00;
      dev_state = 3'(d);
      tick();
      chk("R7 forced L1", int'(link_state), L1);
      turnoff_req = 1'b1;
      tick();
      turnoff_req = 1'b0;
      chk("R8 turnoff state", int'(link_state), (d == 3) ? L23 : L1);
      chk("R8 turnoff ack", int'(turnoff_ack), (d == 3) ? 1 : 0);
      rx_l1_req = 1'b1;
      tick();
      rx_l1_req = 1'b0;
      if (d == 3) begin
        chk("R9 no ack in staged", int'(ack_pos | ack_neg), 0);
        chk("R9 state kept", int'(link_state), L23);
      end else begin
        chk("R4 negative in L1", int'(ack_neg), 1);
      end
      dev_state = 3'd0;
      tick();
      chk("R11 recovery", int'(link_state), RCV);
      recov_to_l0("R11 back to L0");
    end

    for (int d = 4; d <= 7; d++) begin
      do_reset();
      aspm_ctl = 2'b11;
      dev_state = 3'(d);
      tick();
      chk("R10 powered down", int'(link_state), OFF);
      rx_l1_req = 1'b1;
      tick();
      rx_l1_req = 1'b0;
      chk("R9 no ack powered down", int'(ack_pos | ack_neg), 0);
      dev_state = 3'd0;
      tick();
      chk("R11 recovery from off", int'(link_state), RCV);
    end

    // R8 ignored cases
    do_reset();
    turnoff_req = 1'b1;
    tick();
    turnoff_req = 1'b0;
    chk("R8 ignored in D0 ack", int'(turnoff_ack), 0);
    chk("R8 ignored in D0 state", int'(link_state), L0);
    dev_state = 3'd3;
    turnoff_req = 1'b1;
    tick();
    turnoff_req = 1'b0;
    chk("R8 ignored before L1 ack", int'(turnoff_ack), 0);
    chk("R8 ignored before L1 state", int'(link_state), L1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule